// File: doc/BRIEF.md
# Vectored Interrupt Cause and Mask Controller

This block gathers hardware event causes into a cause register of up to 32 bits. It gates them with an enable mask and turns them into message requests, one request line per message vector. The part of the system that sends the actual message watches a request line and answers on the matching acknowledge line. Software reaches the block through a single-cycle register port. Read data is combinational during the cycle in which `reg_rd` is high. Every side effect of a read or a write, such as clearing bits or masking, takes place at the clock edge that ends that cycle.

There are two routing modes. In single-vector mode every cause feeds vector 0. In multi-vector mode each cause has a mapping entry that names its vector and carries a valid bit. When a vector's message is raised, two policies can act on the causes that belong to that vector. Auto-clear removes those causes from the cause register, so one message is sent per burst of events. Auto-mask removes them from the enable mask. Auto-mask can instead be tied to software accesses of the cause register.

Each vector is run by a small state machine with two states. `VS_IDLE` means no message is outstanding. `VS_WAIT` means a request is being held. The *launch* transition goes from `VS_IDLE` to `VS_WAIT` when the vector has an enabled, routed, set cause. The *retire* transition goes from `VS_WAIT` to `VS_IDLE` when the acknowledge is sampled.

Register word addresses are as follows:
- 0: control. Bit 4 selects multi-vector mode. Bit 30 moves auto-mask to message time.
- 1: cause.
- 2: enable-set.
- 3: enable-clear.
- 4: auto-clear.
- 5: auto-mask.
- 32+i: the mapping entry for cause i.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every register reads as zero and no `msg_req` bit is high. This means all causes are disabled and all mapping entries are invalid.
- R2: A cause bit that is high on `cause_in` in a cycle is set in the cause register (address 1) at that edge. It stays set until something clears it.
- R3: Writing address 2 sets the enable bits written as 1. Writing address 3 clears the enable bits written as 1. Bits written as 0 are left unchanged. Reading either address returns the enable mask.
- R4: Writing address 1 clears the cause bits written as 1. Bits written as 0 are left unchanged.
- R5: Reading address 1 returns the cause register and then clears it.
- R6: If a cause bit is set by `cause_in` in the same cycle that a software write or read of address 1 would clear it, the bit ends up set.
- R7: With control bit 4 at 0, every enabled, set cause requests vector 0. The mapping table is ignored, and the other vectors never request.
- R8: With control bit 4 at 1, cause i requests the vector held in bits [1:0] of entry 32+i, but only if bit 7 of that entry is 1. A cause whose entry is invalid never requests.
- R9: A vector with no outstanding request raises `msg_req` one edge after the cause register holds an enabled cause routed to it. The request is held until `msg_ack` is sampled and drops at that edge. It can rise again at the following edge.
- R10: At the edge where a vector's request rises, the causes of that vector whose bit is set in the auto-clear register (address 4) are cleared.
- R11: With control bit 30 at 1, at the edge where a vector's request rises, the enables of that vector's causes whose bit is set in the auto-mask register (address 5) are cleared. A cause that re-asserts afterwards sends no message until software sets the enable again.
- R12: With control bit 30 at 0, any read or write of address 1 clears the enables whose bit is set in the auto-mask register. Raising a message leaves the enables untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| cause_in | input | NUM_CAUSES (32) | Hardware event causes, sampled every edge |
| msg_req | output | NUM_VECS (4) | Per-vector message request, held until acknowledged |
| msg_ack | input | NUM_VECS (4) | Per-vector acknowledge |

## Verification
Several functions can land on the same clock edge, and the bench provokes each of these collisions on purpose.
- A hardware cause set can coincide with a software clear of the same bit, either a write-one-to-clear or a read-to-clear. The bench drives a `cause_in` pulse in the very cycle of the write or read and then expects the bit to read back as set.
- A message launch can coincide with auto-clear and auto-mask. The bench reads the cause and enable registers on the cycle right after the request rises, and in both auto-mask modes.

A behavioural reference model in the bench predicts `msg_req` on every clock and predicts every value read back.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int MAP_BASE = 32;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'd0;
    localparam logic [ADDR_W-1:0] A_CAUSE = 6'd1;
    localparam logic [ADDR_W-1:0] A_MSET  = 6'd2;
    localparam logic [ADDR_W-1:0] A_MCLR  = 6'd3;
    localparam logic [ADDR_W-1:0] A_ACLR  = 6'd4;
    localparam logic [ADDR_W-1:0] A_AMSK  = 6'd5;

    localparam int CTRL_MULTI_BIT = 4;
    localparam int CTRL_AMSG_BIT  = 30;
    localparam int MAP_VLD_BIT    = 7;

    typedef enum logic [0:0] {
        VS_IDLE = 1'b0,
        VS_WAIT = 1'b1
    } vec_state_t;
endpackage

// File: rtl/ivc_vec_fsm.sv
module ivc_vec_fsm
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic ack,
    output logic launch,
    output logic req
);
    vec_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            VS_IDLE: begin
                if (pending) begin
                    state_d = VS_WAIT;
                    launch  = 1'b1;
                end
            end
            VS_WAIT: begin
                if (ack) state_d = VS_IDLE;
            end
            default: state_d = VS_IDLE;
        endcase
    end

    assign req = (state_q == VS_WAIT);

    // R9: request held while unacknowledged
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    // R9: request drops at the acknowledge edge
    assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);
    // R9: idle vector with work raises its request next edge
    assert_req_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && pending) |=> req);
endmodule

// File: rtl/ivc_router.sv
module ivc_router #(
    parameter int NC = 32,
    parameter int NV = 4,
    parameter int VW = 2
) (
    input  logic                   multi,
    input  logic [NC-1:0][VW-1:0]  map_vec,
    input  logic [NC-1:0]          map_vld,
    input  logic [NC-1:0]          cause_q,
    input  logic [NC-1:0]          en_q,
    input  logic [NV-1:0]          launch,
    output logic [NV-1:0]          pending,
    output logic [NC-1:0]          hit_mask
);
    logic [NV-1:0][NC-1:0] member;
    logic [NV-1:0][NC-1:0] hit_part;

    for (genvar v = 0; v < NV; v++) begin : g_vec
        for (genvar i = 0; i < NC; i++) begin : g_cause
            if (v == 0) begin : g_v0
                assign member[v][i] = multi ? (map_vld[i] && (map_vec[i] == VW'(v))) : 1'b1;
            end else begin : g_vn
                assign member[v][i] = multi && map_vld[i] && (map_vec[i] == VW'(v));
            end
        end
        assign pending[v]  = |(cause_q & en_q & member[v]);
        assign hit_part[v] = launch[v] ? member[v] : '0;
    end

    always_comb begin
        hit_mask = '0;
        for (int v = 0; v < NV; v++) hit_mask = hit_mask | hit_part[v];
    end
endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
    import irq_vec_pkg::*;
#(
    parameter int NC = 32,
    parameter int VW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NC-1:0]         cause_in,
    input  logic [NC-1:0]         hit_mask,
    output logic [NC-1:0]         cause_q,
    output logic [NC-1:0]         en_q,
    output logic                  multi_q,
    output logic [NC-1:0][VW-1:0] map_vec_q,
    output logic [NC-1:0]         map_vld_q
);
    logic          amsg_q;
    logic [NC-1:0] aclr_q, amsk_q;
    logic [NC-1:0] wdat;
    logic          wr_cause, rd_cause, cause_acc, wr_mset, wr_mclr;
    logic [NC-1:0] sw_clr, ac_clr, am_clr, cause_d, en_d;

    assign wdat      = reg_wdata[NC-1:0];
    assign wr_cause  = reg_wr && (reg_addr == A_CAUSE);
    assign rd_cause  = reg_rd && (reg_addr == A_CAUSE);
    assign cause_acc = wr_cause || rd_cause;
    assign wr_mset   = reg_wr && (reg_addr == A_MSET);
    assign wr_mclr   = reg_wr && (reg_addr == A_MCLR);

    always_comb begin
        sw_clr = '0;
        if (wr_cause)      sw_clr = wdat;
        else if (rd_cause) sw_clr = '1;
        ac_clr = aclr_q & hit_mask;
        if (amsg_q)         am_clr = amsk_q & hit_mask;
        else if (cause_acc) am_clr = amsk_q;
        else                am_clr = '0;
        cause_d = (cause_q & ~sw_clr & ~ac_clr) | cause_in;
        en_d    = (en_q & ~(wr_mclr ? wdat : '0) & ~am_clr) | (wr_mset ? wdat : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            en_q    <= '0;
            multi_q <= 1'b0;
            amsg_q  <= 1'b0;
            aclr_q  <= '0;
            amsk_q  <= '0;
        end else begin
            cause_q <= cause_d;
            en_q    <= en_d;
            if (reg_wr && reg_addr == A_CTRL) begin
                multi_q <= reg_wdata[CTRL_MULTI_BIT];
                amsg_q  <= reg_wdata[CTRL_AMSG_BIT];
            end
            if (reg_wr && reg_addr == A_ACLR) aclr_q <= wdat;
            if (reg_wr && reg_addr == A_AMSK) amsk_q <= wdat;
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_vec_q[i] <= '0;
                map_vld_q[i] <= 1'b0;
            end else if (reg_wr && reg_addr == ADDR_W'(MAP_BASE + i)) begin
                map_vec_q[i] <= reg_wdata[VW-1:0];
                map_vld_q[i] <= reg_wdata[MAP_VLD_BIT];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                A_CTRL: begin
                    reg_rdata[CTRL_MULTI_BIT] = multi_q;
                    reg_rdata[CTRL_AMSG_BIT]  = amsg_q;
                end
                A_CAUSE: reg_rdata = DATA_W'(cause_q);
                A_MSET:  reg_rdata = DATA_W'(en_q);
                A_MCLR:  reg_rdata = DATA_W'(en_q);
                A_ACLR:  reg_rdata = DATA_W'(aclr_q);
                A_AMSK:  reg_rdata = DATA_W'(amsk_q);
                default: begin
                    for (int i = 0; i < NC; i++) begin
                        if (reg_addr == ADDR_W'(MAP_BASE + i)) begin
                            reg_rdata[VW-1:0]       = map_vec_q[i];
                            reg_rdata[MAP_VLD_BIT]  = map_vld_q[i];
                        end
                    end
                end
            endcase
        end
    end

    // R3: enable-set and enable-clear act on written ones
    assert_mset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((en_q & $past(wdat)) == $past(wdat)));
    assert_mclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((en_q & $past(wdat)) == '0));
    // R4: write-one-to-clear of the cause register
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((cause_q & $past(wdat) & ~$past(cause_in)) == '0));
    // R5: read-to-clear of the cause register
    assert_rc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause |=> ((cause_q & ~$past(cause_in)) == '0));
    // R6: a new hardware event is never lost
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_in) |=> ((cause_q & $past(cause_in)) == $past(cause_in)));
    // R10: auto-clear at message launch
    assert_autoclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(aclr_q & hit_mask)) |=> ((cause_q & $past(aclr_q & hit_mask) & ~$past(cause_in)) == '0));
    // R11: auto-mask at message launch
    assert_am_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (amsg_q && !wr_mset && (|(amsk_q & hit_mask))) |=> ((en_q & $past(amsk_q & hit_mask)) == '0));
    // R12: auto-mask on cause access
    assert_am_acc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!amsg_q && cause_acc) |=> ((en_q & $past(amsk_q)) == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_CAUSES = 32,
    parameter int NUM_VECS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_CAUSES-1:0] cause_in,
    output logic [NUM_VECS-1:0]   msg_req,
    input  logic [NUM_VECS-1:0]   msg_ack
);
    localparam int VW = (NUM_VECS > 1) ? $clog2(NUM_VECS) : 1;

    logic [NUM_CAUSES-1:0]         cause_q, en_q, hit_mask;
    logic                          multi_q;
    logic [NUM_CAUSES-1:0][VW-1:0] map_vec_q;
    logic [NUM_CAUSES-1:0]         map_vld_q;
    logic [NUM_VECS-1:0]           pending, launch;

    ivc_regfile #(.NC(NUM_CAUSES), .VW(VW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cause_in  (cause_in),
        .hit_mask  (hit_mask),
        .cause_q   (cause_q),
        .en_q      (en_q),
        .multi_q   (multi_q),
        .map_vec_q (map_vec_q),
        .map_vld_q (map_vld_q)
    );

    ivc_router #(.NC(NUM_CAUSES), .NV(NUM_VECS), .VW(VW)) u_route (
        .multi    (multi_q),
        .map_vec  (map_vec_q),
        .map_vld  (map_vld_q),
        .cause_q  (cause_q),
        .en_q     (en_q),
        .launch   (launch),
        .pending  (pending),
        .hit_mask (hit_mask)
    );

    for (genvar v = 0; v < NUM_VECS; v++) begin : g_fsm
        ivc_vec_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .pending (pending[v]),
            .ack     (msg_ack[v]),
            .launch  (launch[v]),
            .req     (msg_req[v])
        );
    end

    // R7: in single-vector mode only vector 0 may request
    assert_single_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_q && msg_req[NUM_VECS-1:1] == '0) |=> (msg_req[NUM_VECS-1:1] == '0));
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    localparam int NC = 32;
    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] cause_in = '0;
    logic [NV-1:0] msg_req;
    logic [NV-1:0] msg_ack = '0;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    irq_vec_ctrl #(.NUM_CAUSES(NC), .NUM_VECS(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cause_in(cause_in), .msg_req(msg_req), .msg_ack(msg_ack)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_cause, m_en, m_aclr, m_amsk;
    bit        m_multi, m_amsg;
    int        m_vec [NC];
    bit        m_vld [NC];
    bit [NV-1:0] m_req;

    function automatic bit belongs(int i, int v);
        if (m_multi) return m_vld[i] && (m_vec[i] == v);
        return v == 0;
    endfunction

    function automatic bit [31:0] model_read(int a);
        bit [31:0] r = 0;
        case (a)
            0: begin r[4] = m_multi; r[30] = m_amsg; end
            1: r = m_cause;
            2, 3: r = m_en;
            4: r = m_aclr;
            5: r = m_amsk;
            default: if (a >= 32 && a < 32 + NC) begin
                r[1:0] = 2'(m_vec[a-32]);
                r[7] = m_vld[a-32];
            end
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        bit [31:0] hit, nc, ne, wd;
        bit [NV-1:0] fire;
        int a;
        if (!rst_n) begin
            m_cause = 0; m_en = 0; m_aclr = 0; m_amsk = 0;
            m_multi = 0; m_amsg = 0; m_req = 0;
            for (int i = 0; i < NC; i++) begin m_vec[i] = 0; m_vld[i] = 0; end
        end else begin
            fire = 0; hit = 0;
            wd = reg_wdata; a = int'(reg_addr);
            for (int v = 0; v < NV; v++)
                if (!m_req[v])
                    for (int i = 0; i < NC; i++)
                        if (m_cause[i] && m_en[i] && belongs(i, v)) fire[v] = 1;
            for (int v = 0; v < NV; v++)
                for (int i = 0; i < NC; i++)
                    if (fire[v] && belongs(i, v)) hit[i] = 1;
            nc = m_cause & ~(m_aclr & hit);
            ne = m_en;
            if (m_amsg) ne = ne & ~(m_amsk & hit);
            if (reg_wr) begin
                case (a)
                    0: ;
                    1: begin nc = nc & ~wd; if (!m_amsg) ne = ne & ~m_amsk; end
                    2: ne = ne | wd;
                    3: ne = ne & ~wd;
                    4: ;
                    5: ;
                    default: ;
                endcase
            end
            if (reg_rd && a == 1) begin
                nc = 0;
                if (!m_amsg) ne = ne & ~m_amsk;
            end
            if (reg_wr && a == 3) ne = ne & ~wd;
            if (reg_wr && a == 2) ne = ne | wd;
            nc = nc | cause_in;
            if (reg_wr) begin
                if (a == 0) begin m_multi = wd[4]; m_amsg = wd[30]; end
                if (a == 4) m_aclr = wd;
                if (a == 5) m_amsk = wd;
                if (a >= 32 && a < 32 + NC) begin m_vec[a-32] = int'(wd[1:0]); m_vld[a-32] = wd[7]; end
            end
            for (int v = 0; v < NV; v++) begin
                if (m_req[v] && msg_ack[v]) m_req[v] = 0;
                else if (fire[v]) m_req[v] = 1;
            end
            m_cause = nc;
            m_en = ne;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R9: request outputs against the model on every clock
    always @(negedge clk) begin
        if (rst_n) check(32'(msg_req), 32'(m_req), "R9 per-cycle msg_req");
    end

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_pulse(input int a, input logic [31:0] d, input logic [31:0] c);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d; cause_in = c;
        @(negedge clk);
        reg_wr = 1'b0; cause_in = '0;
    endtask

    task automatic rd_exp(input int a, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = 6'(a);
        #1;
        check(reg_rdata, exp, tag);
        check(reg_rdata, model_read(a), {tag, " (model)"});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_pulse(input int a, input logic [31:0] exp, input logic [31:0] c, input string tag);
        reg_rd = 1'b1; reg_addr = 6'(a); cause_in = c;
        #1;
        check(reg_rdata, exp, tag);
        @(negedge clk);
        reg_rd = 1'b0; cause_in = '0;
    endtask

    task automatic pulse(input logic [31:0] c);
        cause_in = c;
        @(negedge clk);
        cause_in = '0;
    endtask

    task automatic ack(input int v);
        msg_ack[v] = 1'b1;
        @(negedge clk);
        msg_ack = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check(32'(msg_req), 32'h0, "R1 msg_req after reset");
        rd_exp(0, 32'h0, "R1 control");
        rd_exp(1, 32'h0, "R1 cause");
        rd_exp(2, 32'h0, "R1 enable");
        rd_exp(4, 32'h0, "R1 auto-clear");
        rd_exp(5, 32'h0, "R1 auto-mask");
        rd_exp(33, 32'h0, "R1 map entry");
        // R3 enable set/clear
        wr(2, 32'h3);
        rd_exp(2, 32'h3, "R3 enable-set");
        wr(3, 32'h1);
        rd_exp(3, 32'h2, "R3 enable-clear");
        wr(2, 32'h0); wr(3, 32'h0);
        rd_exp(2, 32'h2, "R3 zeros no change");
        // R2 / R5 capture and read-to-clear of a disabled cause
        pulse(32'h20);
        idle(2);
        check(32'(msg_req), 32'h0, "R7 disabled cause silent");
        rd_exp(1, 32'h20, "R2 cause captured");
        rd_exp(1, 32'h0, "R5 read cleared cause");
        // R4 write-one-to-clear
        pulse(32'h101);
        wr(1, 32'h100);
        wr(1, 32'h0);
        rd_exp(1, 32'h1, "R4 w1c selective");
        // R6 set wins against clear
        wr_pulse(1, 32'h200, 32'h200);
        rd_exp(1, 32'h200, "R6 set beats w1c");
        rd_pulse(1, 32'h0, 32'h400, "R6 read during set");
        rd_exp(1, 32'h400, "R6 set beats read-clear");
        // R7 / R9 single-vector mode, table ignored
        wr(33, 32'h82);
        pulse(32'h2);
        check(32'(msg_req), 32'h0, "R9 no request before latency");
        @(negedge clk);
        check(32'(msg_req), 32'h1, "R7 single mode vector 0");
        idle(3);
        check(32'(msg_req), 32'h1, "R9 request held");
        ack(0);
        check(32'(msg_req), 32'h0, "R9 drop on ack");
        @(negedge clk);
        check(32'(msg_req), 32'h1, "R9 refire while cause set");
        wr(1, 32'hFFFF_FFFF);
        ack(0);
        idle(2);
        check(32'(msg_req), 32'h0, "R9 quiet after clear");
        // R8 multi-vector routing
        wr(0, 32'h10);
        wr(34, 32'h83);
        wr(35, 32'h01);
        wr(2, 32'hE);
        pulse(32'h4);
        @(negedge clk);
        check(32'(msg_req), 32'h8, "R8 cause 2 to vector 3");
        wr(1, 32'hFFFF_FFFF);
        ack(3);
        idle(2);
        pulse(32'h8);
        idle(3);
        check(32'(msg_req), 32'h0, "R8 invalid entry silent");
        rd_exp(1, 32'h8, "R8 invalid cause still held");
        pulse(32'h2);
        @(negedge clk);
        check(32'(msg_req), 32'h4, "R8 cause 1 to vector 2");
        wr(1, 32'hFFFF_FFFF);
        ack(2);
        idle(2);
        // R10 auto-clear at launch
        wr(4, 32'h4);
        pulse(32'h4);
        @(negedge clk);
        check(32'(msg_req), 32'h8, "R10 launch");
        rd_exp(1, 32'h0, "R10 cause auto-cleared");
        ack(3);
        idle(2);
        check(32'(msg_req), 32'h0, "R10 one message per burst");
        // R11 auto-mask at launch
        wr(5, 32'h4);
        wr(0, 32'h4000_0010);
        pulse(32'h4);
        @(negedge clk);
        check(32'(msg_req), 32'h8, "R11 launch");
        rd_exp(2, 32'hA, "R11 enable auto-masked");
        ack(3);
        pulse(32'h4);
        idle(3);
        check(32'(msg_req), 32'h0, "R11 re-assert blocked");
        wr(2, 32'h4);
        check(32'(msg_req), 32'h0, "R11 not yet after unmask");
        @(negedge clk);
        check(32'(msg_req), 32'h8, "R11 fires after unmask");
        ack(3);
        wr(2, 32'h4);
        wr(1, 32'h0);
        rd_exp(2, 32'hE, "R11 cause access keeps enables");
        // R12 auto-mask on cause access
        wr(0, 32'h10);
        pulse(32'h4);
        @(negedge clk);
        check(32'(msg_req), 32'h8, "R12 launch");
        rd_exp(2, 32'hE, "R12 launch keeps enables");
        ack(3);
        wr(1, 32'h0);
        rd_exp(2, 32'hA, "R12 cause write masks");
        idle(2);
        finish_run();
    end
endmodule